// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block is the register front-end and strobe engine of a small NAND flash controller. Software uses 16-bit register writes to load a command byte, an address byte and a buffer number. It then starts an operation by writing a one-hot code into the operation/status register. The block produces the NAND-side pin activity for that operation:

- command latch
- address latch
- page program data out of the internal buffer RAM
- page read data into the buffer RAM
- an identification read
- a status read

When the last strobe ends, the operation bits drop to zero and a sticky completion flag (bit 15) is set. An interrupt line stays high while that flag is set, unless the interrupt is masked. Software clears the flag by writing the register with bit 15 at zero.

The page RAM is a separate memory. This block gives it a byte address made of {buffer number, byte index}, reads it asynchronously and writes it one byte at a time. The RAM lock word and the write-protect word are held as registers. Their unlock values enable buffer writes and release the NAND write-protect pin.

Top module: `nand_op_seq`

## Requirements
- R1: After reset every register reads 0. The buffer-select (0x04), address (0x06), command (0x08), lock (0x0A), write-protect (0x12) and config (0x1A) registers read back what was written. In config, bit 6 always reads 0.
- R2: Op code 0x0001 at 0x1C produces one write strobe (nand_we_n low for PULSE_CLKS clocks, then high for PULSE_CLKS clocks). nand_cle is high during the strobe and nand_io_out carries the low byte of the command register.
- R3: Op code 0x0002 produces the same single strobe with nand_ale high instead of nand_cle, carrying the low byte of the address register. nand_cle and nand_ale are never high together.
- R4: Op code 0x0004 sends one buffer to the NAND. It makes BUF_BYTES write strobes, and strobe i drives the RAM byte at {buffer select, i}.
- R5: Op code 0x0008 first waits until nand_rdy is high. It then makes BUF_BYTES read strobes, and on the last low clock of strobe i it writes nand_io_in to RAM byte {buffer select, i}. buf_we is only ever high while nand_re_n is low.
- R6: Op code 0x0010 reads ID_BYTES bytes and op code 0x0020 reads one byte. Both always go to buffer 0, whatever the buffer-select value.
- R7: While config bit 2 is set, the page operations (0x0004 and 0x0008) move SPARE_BYTES bytes instead of BUF_BYTES.
- R8: At the end of an operation, bit 15 of 0x1C becomes 1 and bits 5:0 become 0. Writing 0x1C with bit 15 at 0 clears the flag. Writing it with bit 15 at 1 leaves the flag set.
- R9: irq is high exactly when the completion flag is set and config bit 4 (mask) is clear.
- R10: The op bits are ignored while an operation is busy (bits 5:0 nonzero), and codes that are not one-hot are ignored. In both cases there are no strobes and the op bits keep their prior value.
- R11: buf_we stays low unless the lock register holds 0x0002.
- R12: nand_wp_n is high only while the write-protect register holds 0x0004.
- R13: Writing config with bit 6 set aborts an operation in progress. Strobes stop, the op bits clear and the completion flag is not set.
- R14: nand_ce_n is low while an operation is busy or config bit 7 is set, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Completion interrupt, level-high |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | NAND data bus, driven value |
| nand_io_oe | output | 1 | NAND data bus output enable |
| nand_io_in | input | 8 | NAND data bus, sampled value |
| nand_rdy | input | 1 | NAND ready/busy, high when ready |
| buf_addr | output | log2(NUM_BUFS)+log2(BUF_BYTES) | Buffer RAM byte address |
| buf_rdata | input | 8 | Buffer RAM read data (asynchronous) |
| buf_we | output | 1 | Buffer RAM byte write enable |
| buf_wdata | output | 8 | Buffer RAM write data |

## Verification
Each operation code is tried in turn.

- Command and address latch runs use several byte values. These show that the right latch pin goes with the right byte, and that each strobe has the right width.
- Page transfers in both directions use a non-zero buffer number and distinct bytes at each position. This shows the buffer select, the byte order and the capture cycle.
- The same page read is run with spare-only mode set. Its shorter count separates the two length modes.
- ID and status reads are made with a non-zero buffer selected. This shows that they go to buffer 0 and leave the selected buffer alone.
- Further cases cover an operation written while another is busy, a code that is not one-hot, a read with the RAM locked, and an abort part-way through a page.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_BUFSEL = 5'h04;
    localparam logic [REG_AW-1:0] OFS_FADDR  = 5'h06;
    localparam logic [REG_AW-1:0] OFS_FCMD   = 5'h08;
    localparam logic [REG_AW-1:0] OFS_LOCK   = 5'h0A;
    localparam logic [REG_AW-1:0] OFS_WPROT  = 5'h12;
    localparam logic [REG_AW-1:0] OFS_CFG    = 5'h1A;
    localparam logic [REG_AW-1:0] OFS_OPSTAT = 5'h1C;

    localparam int OP_CMD  = 0;
    localparam int OP_ADDR = 1;
    localparam int OP_PGIN = 2;
    localparam int OP_PGOUT = 3;
    localparam int OP_ID   = 4;
    localparam int OP_STAT = 5;

    localparam logic [15:0] LOCK_OPEN = 16'h0002;
    localparam logic [15:0] WP_OPEN   = 16'h0004;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_LOW,
        ST_HIGH
    } seq_state_e;

endpackage

// File: rtl/nand_reg_file.sv
module nand_reg_file
    import nand_seq_pkg::*;
#(
    parameter int BSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic              seq_finish,
    output logic              launch,
    output logic              abort,
    output logic [5:0]        op,
    output logic              done,
    output logic [BSEL_W-1:0] bsel,
    output logic [15:0]       faddr,
    output logic [15:0]       fcmd,
    output logic [8:0]        cfg,
    output logic              unlocked,
    output logic              wp_open,
    output logic              irq
);

    typedef struct packed {
        logic [BSEL_W-1:0] bsel;
        logic [15:0]       faddr;
        logic [15:0]       fcmd;
        logic [15:0]       lock;
        logic [15:0]       wprot;
        logic [8:0]        cfg;
        logic [5:0]        op;
        logic              done;
        logic              launch;
        logic              abort;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  code_onehot;

    always_comb begin
        code_onehot = (wdata[5:0] != 6'd0) && ((wdata[5:0] & (wdata[5:0] - 6'd1)) == 6'd0);
        regs_d        = regs_q;
        regs_d.launch = 1'b0;
        regs_d.abort  = 1'b0;
        if (wr_en) begin
            case (addr)
                OFS_BUFSEL: regs_d.bsel  = wdata[BSEL_W-1:0];
                OFS_FADDR:  regs_d.faddr = wdata;
                OFS_FCMD:   regs_d.fcmd  = wdata;
                OFS_LOCK:   regs_d.lock  = wdata;
                OFS_WPROT:  regs_d.wprot = wdata;
                OFS_CFG: begin
                    regs_d.cfg = {wdata[8:7], 1'b0, wdata[5:0]};
                    if (wdata[6]) begin
                        regs_d.abort = 1'b1;
                        regs_d.op    = 6'd0;
                    end
                end
                OFS_OPSTAT: begin
                    if (!wdata[15]) regs_d.done = 1'b0;
                    if (regs_q.op == 6'd0 && code_onehot) begin
                        regs_d.op     = wdata[5:0];
                        regs_d.launch = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (seq_finish && !regs_d.abort) begin
            regs_d.op   = 6'd0;
            regs_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            OFS_BUFSEL: rdata = 16'(regs_q.bsel);
            OFS_FADDR:  rdata = regs_q.faddr;
            OFS_FCMD:   rdata = regs_q.fcmd;
            OFS_LOCK:   rdata = regs_q.lock;
            OFS_WPROT:  rdata = regs_q.wprot;
            OFS_CFG:    rdata = 16'(regs_q.cfg);
            OFS_OPSTAT: rdata = {regs_q.done, 9'd0, regs_q.op};
            default:    rdata = 16'd0;
        endcase
    end

    assign launch   = regs_q.launch;
    assign abort    = regs_q.abort;
    assign op       = regs_q.op;
    assign done     = regs_q.done;
    assign bsel     = regs_q.bsel;
    assign faddr    = regs_q.faddr;
    assign fcmd     = regs_q.fcmd;
    assign cfg      = regs_q.cfg;
    assign unlocked = (regs_q.lock == LOCK_OPEN);
    assign wp_open  = (regs_q.wprot == WP_OPEN);
    assign irq      = regs_q.done && !regs_q.cfg[4];

endmodule

// File: rtl/nand_strobe_fsm.sv
module nand_strobe_fsm
    import nand_seq_pkg::*;
#(
    parameter int BUF_BYTES   = 512,
    parameter int SPARE_BYTES = 16,
    parameter int ID_BYTES    = 6,
    parameter int PULSE_CLKS  = 2,
    parameter int BSEL_W      = 2,
    parameter int IDX_W       = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic                    abort,
    input  logic [5:0]              op_in,
    input  logic                    spare_only,
    input  logic [BSEL_W-1:0]       bsel,
    input  logic [7:0]              cmd_byte,
    input  logic [7:0]              addr_byte,
    input  logic                    nand_rdy,
    input  logic [7:0]              io_in,
    input  logic [7:0]              buf_rdata,
    output logic                    cle,
    output logic                    ale,
    output logic                    we_n,
    output logic                    re_n,
    output logic [7:0]              io_out,
    output logic                    io_oe,
    output logic [BSEL_W+IDX_W-1:0] buf_addr,
    output logic                    capture,
    output logic [7:0]              buf_wdata,
    output logic                    finish
);

    localparam int PC_W = $clog2(PULSE_CLKS + 1);
    localparam int BC_W = $clog2(BUF_BYTES + 1);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CLKS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [5:0]        op;
        logic [BSEL_W-1:0] sel;
        logic [PC_W-1:0]   pcnt;
        logic [BC_W-1:0]   bcnt;
        logic [BC_W-1:0]   last;
    } seq_t;

    seq_t seq_d, seq_q;
    logic is_read;

    assign is_read = seq_q.op[OP_PGOUT] | seq_q.op[OP_ID] | seq_q.op[OP_STAT];

    always_comb begin
        seq_d  = seq_q;
        finish = 1'b0;
        case (seq_q.st)
            ST_IDLE: if (launch) begin
                seq_d.op   = op_in;
                seq_d.pcnt = '0;
                seq_d.bcnt = '0;
                seq_d.sel  = (op_in[OP_ID] | op_in[OP_STAT]) ? '0 : bsel;
                if (op_in[OP_PGIN] | op_in[OP_PGOUT])
                    seq_d.last = spare_only ? BC_W'(SPARE_BYTES - 1) : BC_W'(BUF_BYTES - 1);
                else if (op_in[OP_ID])
                    seq_d.last = BC_W'(ID_BYTES - 1);
                else
                    seq_d.last = '0;
                seq_d.st = op_in[OP_PGOUT] ? ST_WAIT_RDY : ST_LOW;
            end
            ST_WAIT_RDY: if (nand_rdy) seq_d.st = ST_LOW;
            ST_LOW: begin
                if (seq_q.pcnt == PC_LAST) begin
                    seq_d.pcnt = '0;
                    seq_d.st   = ST_HIGH;
                end else begin
                    seq_d.pcnt = seq_q.pcnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (seq_q.pcnt == PC_LAST) begin
                    seq_d.pcnt = '0;
                    if (seq_q.bcnt == seq_q.last) begin
                        seq_d.st = ST_IDLE;
                        finish   = 1'b1;
                    end else begin
                        seq_d.bcnt = seq_q.bcnt + 1'b1;
                        seq_d.st   = ST_LOW;
                    end
                end else begin
                    seq_d.pcnt = seq_q.pcnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (abort) begin
            seq_d.st = ST_IDLE;
            finish   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign cle       = (seq_q.st != ST_IDLE) && seq_q.op[OP_CMD];
    assign ale       = (seq_q.st != ST_IDLE) && seq_q.op[OP_ADDR];
    assign we_n      = !((seq_q.st == ST_LOW) && !is_read);
    assign re_n      = !((seq_q.st == ST_LOW) && is_read);
    assign io_oe     = (seq_q.st != ST_IDLE) && !is_read;
    assign io_out    = seq_q.op[OP_CMD]  ? cmd_byte :
                       seq_q.op[OP_ADDR] ? addr_byte : buf_rdata;
    assign buf_addr  = {seq_q.sel, seq_q.bcnt[IDX_W-1:0]};
    assign capture   = (seq_q.st == ST_LOW) && is_read && (seq_q.pcnt == PC_LAST);
    assign buf_wdata = io_in;

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int BUF_BYTES   = 512,
    parameter int SPARE_BYTES = 16,
    parameter int ID_BYTES    = 6,
    parameter int PULSE_CLKS  = 2,
    parameter int NUM_BUFS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rdy,
    output logic [$clog2(NUM_BUFS)+$clog2(BUF_BYTES)-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata
);

    localparam int BSEL_W = $clog2(NUM_BUFS);
    localparam int IDX_W  = $clog2(BUF_BYTES);

    logic              launch, abort, seq_finish, capture, unlocked, wp_open, done;
    logic [5:0]        cfg2_op;
    logic [BSEL_W-1:0] bsel;
    logic [15:0]       faddr, fcmd;
    logic [8:0]        cfg;

    nand_reg_file #(.BSEL_W(BSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .seq_finish(seq_finish),
        .launch(launch), .abort(abort), .op(cfg2_op), .done(done),
        .bsel(bsel), .faddr(faddr), .fcmd(fcmd), .cfg(cfg),
        .unlocked(unlocked), .wp_open(wp_open), .irq(irq)
    );

    nand_strobe_fsm #(
        .BUF_BYTES(BUF_BYTES), .SPARE_BYTES(SPARE_BYTES), .ID_BYTES(ID_BYTES),
        .PULSE_CLKS(PULSE_CLKS), .BSEL_W(BSEL_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .abort(abort),
        .op_in(cfg2_op), .spare_only(cfg[2]), .bsel(bsel),
        .cmd_byte(fcmd[7:0]), .addr_byte(faddr[7:0]), .nand_rdy(nand_rdy),
        .io_in(nand_io_in), .buf_rdata(buf_rdata), .cle(nand_cle),
        .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .io_out(nand_io_out), .io_oe(nand_io_oe), .buf_addr(buf_addr),
        .capture(capture), .buf_wdata(buf_wdata), .finish(seq_finish)
    );

    assign buf_we    = capture && unlocked;
    assign nand_wp_n = wp_open;
    assign nand_ce_n = !((cfg2_op != 6'd0) || cfg[7]);

endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk #(
    parameter int PULSE_CLKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       we_n,
    input logic       re_n,
    input logic       cle,
    input logic       ale,
    input logic       ce_n,
    input logic       irq,
    input logic       mask,
    input logic       buf_we,
    input logic       abort,
    input logic       done,
    input logic [5:0] op_bits
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_cnt <= '0;
        else if (!we_n) low_cnt <= low_cnt + 16'd1;
        else            low_cnt <= '0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R2

    AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && !$past(abort)) |-> (low_cnt == 16'(PULSE_CLKS))); // R2

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R3

    AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !re_n); // R5

    AST_DONE_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (op_bits == 6'd0)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq); // R9

    AST_BUSY_OP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bits != 6'd0 && $past(op_bits) != 6'd0) |-> (op_bits == $past(op_bits))); // R10

    AST_CE_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n); // R14

endmodule

bind nand_op_seq nand_op_seq_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .we_n(nand_we_n), .re_n(nand_re_n),
    .cle(nand_cle), .ale(nand_ale), .ce_n(nand_ce_n), .irq(irq),
    .mask(cfg[4]), .buf_we(buf_we), .abort(abort), .done(done),
    .op_bits(cfg2_op)
);

// File: tb/nand_op_seq_tb.sv
module nand_op_seq_tb;

    localparam int BUF_BYTES = 16;
    localparam int SPARE_BYTES = 4;
    localparam int ID_BYTES = 5;
    localparam int PULSE_CLKS = 2;
    localparam int NUM_BUFS = 4;
    localparam int BA_W = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq, ce_n, cle, ale, we_n, re_n, wp_n, io_oe, buf_we, rdy;
    logic [7:0] io_out, io_in, buf_rdata, buf_wdata;
    logic [BA_W-1:0] buf_addr;

    logic [7:0] ram [0:63];
    int we_cnt = 0, re_cnt = 0, bwe_cnt = 0, last_low = 0, low_run = 0;
    logic last_cle = 0, last_ale = 0;
    logic [7:0] wr_log [0:63];
    logic prev_we = 1, prev_re = 1;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    nand_op_seq #(.BUF_BYTES(BUF_BYTES), .SPARE_BYTES(SPARE_BYTES), .ID_BYTES(ID_BYTES),
                  .PULSE_CLKS(PULSE_CLKS), .NUM_BUFS(NUM_BUFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .nand_ce_n(ce_n),
        .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_wp_n(wp_n), .nand_io_out(io_out), .nand_io_oe(io_oe),
        .nand_io_in(io_in), .nand_rdy(rdy), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata)
    );

    assign buf_rdata = ram[buf_addr];
    assign io_in = 8'h40 + 8'(re_cnt * 3);

    always @(posedge clk) if (buf_we) ram[buf_addr] <= buf_wdata;

    always @(negedge clk) begin
        if (buf_we) bwe_cnt <= bwe_cnt + 1;
        if (prev_we && !we_n) begin
            last_cle <= cle; last_ale <= ale; low_run <= 1;
        end else if (!we_n) low_run <= low_run + 1;
        if (!prev_we && we_n) begin
            wr_log[we_cnt[5:0]] <= io_out;
            we_cnt <= we_cnt + 1;
            last_low <= low_run;
        end
        if (!prev_re && re_n) re_cnt <= re_cnt + 1;
        prev_we <= we_n;
        prev_re <= re_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [15:0] v;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h1C, v);
            if (v[15]) begin ok = 1; break; end
        end
    endtask

    typedef struct packed {
        logic [15:0] opc;
        logic [7:0]  val;
        logic        use_cle;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{16'h0001, 8'h70, 1'b1},
        '{16'h0002, 8'h12, 1'b0},
        '{16'h0001, 8'hFF, 1'b1},
        '{16'h0002, 8'hA5, 1'b0}
    };

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        bit ok;
        int base, rb;
        for (int i = 0; i < 64; i++) ram[i] = 8'(i);
        rdy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R12, R14 reset state
        for (int i = 0; i < 7; i++) begin
            logic [4:0] a;
            a = (i == 0) ? 5'h04 : (i == 1) ? 5'h06 : (i == 2) ? 5'h08 : (i == 3) ? 5'h0A :
                (i == 4) ? 5'h12 : (i == 5) ? 5'h1A : 5'h1C;
            rd(a, v);
            chk(v == 16'h0, "R1 reset value", v, 0);
        end
        chk(irq == 0 && ce_n == 1 && wp_n == 0 && we_n == 1 && re_n == 1, "R12 R14 reset pins",
            {irq, ce_n, wp_n, we_n, re_n}, 5'b01011);

        // R1 readback
        wr(5'h04, 16'h0003); rd(5'h04, v); chk(v == 16'h3, "R1 bufsel readback", v, 3);
        wr(5'h06, 16'hBEEF); rd(5'h06, v); chk(v == 16'hBEEF, "R1 addr readback", v, 16'hBEEF);
        wr(5'h1A, 16'h01FF); rd(5'h1A, v); chk(v == 16'h01BF, "R1 cfg bit6 reads 0", v, 16'h01BF);
        chk(ce_n == 0, "R14 ce forced by cfg bit7", ce_n, 0);
        wr(5'h1A, 16'h0000);
        chk(ce_n == 1, "R14 ce released", ce_n, 1);

        // R12, R11 unlock
        wr(5'h12, 16'h0005); chk(wp_n == 0, "R12 wp stays low for 5", wp_n, 0);
        wr(5'h12, 16'h0004); chk(wp_n == 1, "R12 wp released by 4", wp_n, 1);
        wr(5'h0A, 16'h0002); rd(5'h0A, v); chk(v == 16'h2, "R1 lock readback", v, 2);

        // R2 R3 table walk
        for (int k = 0; k < 4; k++) begin
            base = we_cnt;
            if (VECS[k].use_cle) wr(5'h08, {8'h00, VECS[k].val});
            else                 wr(5'h06, {8'h00, VECS[k].val});
            wr(5'h1C, VECS[k].opc);
            wait_done(ok);
            chk(ok, "R8 latch op completes", ok, 1);
            repeat (2) @(negedge clk);
            chk(we_cnt - base == 1, "R2 R3 one strobe", we_cnt - base, 1);
            chk(wr_log[base[5:0]] == VECS[k].val, "R2 R3 strobe byte", wr_log[base[5:0]], VECS[k].val);
            chk(last_cle == VECS[k].use_cle && last_ale == !VECS[k].use_cle, "R2 R3 latch pin",
                {last_cle, last_ale}, {VECS[k].use_cle, !VECS[k].use_cle});
            chk(last_low == PULSE_CLKS, "R2 low width", last_low, PULSE_CLKS);
            rd(5'h1C, v); chk(v == 16'h8000, "R8 done set op clear", v, 16'h8000);
            wr(5'h1C, 16'h0000);
        end

        // R8 R9 flag and irq
        wr(5'h08, 16'h0090); wr(5'h1C, 16'h0001); wait_done(ok);
        chk(irq == 1, "R9 irq on done", irq, 1);
        wr(5'h1A, 16'h0010); chk(irq == 0, "R9 irq masked", irq, 0);
        wr(5'h1A, 16'h0000); chk(irq == 1, "R9 irq unmasked", irq, 1);
        wr(5'h1C, 16'h8000); rd(5'h1C, v); chk(v == 16'h8000, "R8 write of 1 keeps flag", v, 16'h8000);
        wr(5'h1C, 16'h0000); rd(5'h1C, v); chk(v == 16'h0000, "R8 flag cleared", v, 0);
        chk(irq == 0, "R9 irq drops", irq, 0);

        // R4 page to NAND from buffer 2
        for (int i = 0; i < 16; i++) ram[32 + i] = 8'hC0 + 8'(i);
        wr(5'h04, 16'h0002);
        base = we_cnt; rb = re_cnt;
        wr(5'h1C, 16'h0004); wait_done(ok);
        repeat (2) @(negedge clk);
        chk(we_cnt - base == BUF_BYTES, "R4 strobe count", we_cnt - base, BUF_BYTES);
        chk(re_cnt == rb, "R4 no read strobes", re_cnt - rb, 0);
        for (int i = 0; i < 16; i++)
            chk(wr_log[6'(base + i)] == 8'hC0 + 8'(i), "R4 byte order", wr_log[6'(base + i)], 8'hC0 + i);
        wr(5'h1C, 16'h0000);

        // R5 R10 R14 page from NAND into buffer 1, gated by ready
        rdy = 1'b0;
        wr(5'h04, 16'h0001);
        base = re_cnt;
        wr(5'h1C, 16'h0008);
        repeat (20) @(negedge clk);
        chk(re_cnt == base, "R5 waits for ready", re_cnt - base, 0);
        chk(ce_n == 0, "R14 ce during op", ce_n, 0);
        rb = we_cnt;
        wr(5'h1C, 16'h0001);
        repeat (10) @(negedge clk);
        rd(5'h1C, v); chk(v == 16'h0008, "R10 busy write ignored", v, 8);
        chk(we_cnt == rb, "R10 no strobe from ignored code", we_cnt - rb, 0);
        rdy = 1'b1;
        wait_done(ok);
        chk(re_cnt - base == BUF_BYTES, "R5 read strobe count", re_cnt - base, BUF_BYTES);
        for (int i = 0; i < 16; i++)
            chk(ram[16 + i] == 8'h40 + 8'((base + i) * 3), "R5 captured byte",
                ram[16 + i], 8'h40 + 8'((base + i) * 3));
        wr(5'h1C, 16'h0000);

        // R7 spare-only length
        wr(5'h1A, 16'h0004);
        base = re_cnt;
        wr(5'h1C, 16'h0008); wait_done(ok);
        chk(re_cnt - base == SPARE_BYTES, "R7 spare count", re_cnt - base, SPARE_BYTES);
        wr(5'h1C, 16'h0000);
        base = we_cnt;
        wr(5'h1C, 16'h0004); wait_done(ok);
        repeat (2) @(negedge clk);
        chk(we_cnt - base == SPARE_BYTES, "R7 spare write count", we_cnt - base, SPARE_BYTES);
        wr(5'h1A, 16'h0000); wr(5'h1C, 16'h0000);

        // R6 ID and status into buffer 0 with buffer 3 selected
        wr(5'h04, 16'h0003);
        for (int i = 0; i < 16; i++) ram[48 + i] = 8'h5A;
        base = re_cnt;
        wr(5'h1C, 16'h0010); wait_done(ok);
        chk(re_cnt - base == ID_BYTES, "R6 id count", re_cnt - base, ID_BYTES);
        for (int i = 0; i < ID_BYTES; i++)
            chk(ram[i] == 8'h40 + 8'((base + i) * 3), "R6 id in buffer 0", ram[i], 8'h40 + 8'((base + i) * 3));
        wr(5'h1C, 16'h0000);
        base = re_cnt;
        wr(5'h1C, 16'h0020); wait_done(ok);
        chk(re_cnt - base == 1, "R6 status count", re_cnt - base, 1);
        chk(ram[0] == 8'h40 + 8'(base * 3), "R6 status in buffer 0", ram[0], 8'h40 + 8'(base * 3));
        chk(ram[48] == 8'h5A, "R6 selected buffer untouched", ram[48], 8'h5A);
        wr(5'h1C, 16'h0000);

        // R10 non-one-hot code
        base = we_cnt; rb = re_cnt;
        wr(5'h1C, 16'h0003);
        repeat (20) @(negedge clk);
        rd(5'h1C, v);
        chk(v == 16'h0 && we_cnt == base && re_cnt == rb, "R10 non-onehot ignored", v, 0);

        // R11 locked buffer
        wr(5'h0A, 16'h0000);
        base = bwe_cnt;
        wr(5'h1C, 16'h0020); wait_done(ok);
        chk(bwe_cnt == base, "R11 no buffer write when locked", bwe_cnt - base, 0);
        wr(5'h0A, 16'h0002); wr(5'h1C, 16'h0000);

        // R13 abort mid-page
        base = we_cnt;
        wr(5'h1C, 16'h0004);
        repeat (10) @(negedge clk);
        wr(5'h1A, 16'h0040);
        repeat (4) @(negedge clk);
        rb = we_cnt;
        repeat (40) @(negedge clk);
        chk(we_cnt == rb && rb - base < BUF_BYTES, "R13 strobes stop", we_cnt - base, rb - base);
        rd(5'h1C, v); chk(v == 16'h0, "R13 op cleared no flag", v, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule